// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block holds the control registers of an audio codec mixer: a 256-byte space of 16-bit registers that a host reaches with word-sized I/O accesses. Every write passes through a per-register policy. Some registers keep only certain bits. Some are read-only identity values. Some are sticky status bits. The sample-rate registers take a write only when their variable-rate enable is set. A write of any value to offset 0x00 returns every register to its power-up value.

The stored values are decoded continuously into the fields the audio datapath needs: mute flags, left and right attenuation or gain, left and right record source, and three sample rates. Reads are registered. Each access is a single-cycle pulse on `acc_valid`. A read answers on `rd_data` in the following cycle, with `rd_valid` high.

Top module: `cmx_top`

## Requirements
- R1: Only word accesses (`acc_size`=1) are served. Byte (0) and doubleword (2) reads return 0xFFFF, and byte and doubleword writes change nothing. A word read at a byte address of 0x100 or above returns 0xFFFF, and a word write there changes nothing. A word access uses address bits 7:1 as the register index.
- R2: Writes are masked as follows: master volume (0x02) keeps the bits in 0xBF3F, PCM-out volume (0x18) keeps 0x9F1F, record gain (0x1C) keeps 0x8F0F, and record select (0x1A) keeps 0x0707.
- R3: On power-down control/status (0x26), write bits 15 and 3:0 are dropped, and bits 3:0 keep their current value, which is 0xF after reset.
- R4: The identity registers 0x7C (0x8384), 0x7E (0x7600) and 0x28 (0x0809) ignore writes.
- R5: The front DAC rate (0x2C) and the left/right ADC rate (0x32) are written only while bit 0 of extended control (0x2A) is set. The mic ADC rate (0x34) is written only while bit 3 of extended control is set.
- R6: A write to 0x2A stores the full value. If that value has bit 0 clear, it forces 0x2C and 0x32 to 0xBB80. If it has bit 3 clear, it forces 0x34 to 0xBB80.
- R7: Writes to the unemulated registers 0x04, 0x06, 0x08, 0x0A, 0x0C, 0x0E, 0x10, 0x12, 0x14, 0x16, 0x1E, 0x20 and 0x22 are ignored. Any other offset not named in R2 to R8 stores the written value as it is.
- R8: A word write of any value to offset 0x00 restores every register to its reset value in the next cycle.
- R9: After reset, registers hold these values and all others hold 0: 0x02 = 0x8000, 0x18 = 0x8808, 0x1C = 0x8808, 0x26 = 0x000F, 0x2A = 0x0009, and 0x2C, 0x2E, 0x30, 0x32, 0x34 = 0xBB80, together with the identity values of R4.
- R10: The decoded outputs follow the stored registers. Mute is bit 15. The left field starts at bit 8 and the right field starts at bit 0, with widths of 6 (master), 5 (PCM) and 4 (record gain). The record sources are bits 10:8 (left) and 2:0 (right). The three rates are the full registers 0x2C, 0x32 and 0x34.
- R11: A read accepted in one cycle drives `rd_valid` high with its data in the next cycle. `rd_valid` is low in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 word, 2 doubleword |
| acc_addr | input | 10 | Byte address within the I/O window |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| master_mute | output | 1 | Master mute |
| master_att_l | output | 6 | Master left attenuation |
| master_att_r | output | 6 | Master right attenuation |
| pcm_mute | output | 1 | PCM-out mute |
| pcm_att_l | output | 5 | PCM left attenuation |
| pcm_att_r | output | 5 | PCM right attenuation |
| rec_mute | output | 1 | Record mute |
| rec_gain_l | output | 4 | Record left gain |
| rec_gain_r | output | 4 | Record right gain |
| rec_src_l | output | 3 | Left record source |
| rec_src_r | output | 3 | Right record source |
| rate_dac | output | 16 | Front DAC sample rate |
| rate_adc | output | 16 | Left/right ADC sample rate |
| rate_mic | output | 16 | Mic ADC sample rate |

## Verification
The bench targets the rate interlock. It writes a rate, then clears the enable and checks that the rate falls back to 0xBB80. It then checks that a later rate write is refused while the enable stays clear. A design that tested the new enable value instead of the stored one, or that skipped the forced reload, would read back the stale rate. A word write at 0x140 is checked so that it does not alias onto 0x40, which catches a missing range guard. The power-down register is written with all ones and then with all zeros, which exposes a design that lets the low status nibble follow the write data. A soft reset followed by reads of an ordinary location and of the default-bearing registers catches a reset that restores only part of the space.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int DW = 16;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [DW-1:0] RATE_48K = 16'hBB80;

  // Byte offsets; software decodes these, so they are fixed.
  localparam logic [7:0] OFF_RESET   = 8'h00;
  localparam logic [7:0] OFF_MASTER  = 8'h02;
  localparam logic [7:0] OFF_PCM     = 8'h18;
  localparam logic [7:0] OFF_RECSEL  = 8'h1A;
  localparam logic [7:0] OFF_RECGAIN = 8'h1C;
  localparam logic [7:0] OFF_PWR     = 8'h26;
  localparam logic [7:0] OFF_EXTID   = 8'h28;
  localparam logic [7:0] OFF_EXTCTL  = 8'h2A;
  localparam logic [7:0] OFF_DAC     = 8'h2C;
  localparam logic [7:0] OFF_SURR    = 8'h2E;
  localparam logic [7:0] OFF_LFE     = 8'h30;
  localparam logic [7:0] OFF_ADC     = 8'h32;
  localparam logic [7:0] OFF_MIC     = 8'h34;
  localparam logic [7:0] OFF_VID1    = 8'h7C;
  localparam logic [7:0] OFF_VID2    = 8'h7E;

  localparam int EXT_VAR_AUDIO = 0;
  localparam int EXT_VAR_MIC   = 3;

  function automatic logic [DW-1:0] cmx_default(input logic [7:0] off);
    case (off)
      OFF_MASTER:                 return 16'h8000;
      OFF_PCM, OFF_RECGAIN:       return 16'h8808;
      OFF_PWR:                    return 16'h000F;
      OFF_EXTID:                  return 16'h0809;
      OFF_EXTCTL:                 return 16'h0009;
      OFF_DAC, OFF_SURR, OFF_LFE,
      OFF_ADC, OFF_MIC:           return RATE_48K;
      OFF_VID1:                   return 16'h8384;
      OFF_VID2:                   return 16'h7600;
      default:                    return '0;
    endcase
  endfunction

  // Offsets whose contents never change by a write.
  function automatic logic cmx_frozen(input logic [7:0] off);
    case (off)
      8'h04, 8'h06, 8'h08, 8'h0A, 8'h0C, 8'h0E, 8'h10, 8'h12,
      8'h14, 8'h16, 8'h1E, 8'h20, 8'h22,
      OFF_EXTID, OFF_VID1, OFF_VID2: return 1'b1;
      default:                       return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] cmx_keep_mask(input logic [7:0] off);
    case (off)
      OFF_MASTER:  return 16'hBF3F;
      OFF_PCM:     return 16'h9F1F;
      OFF_RECGAIN: return 16'h8F0F;
      OFF_RECSEL:  return 16'h0707;
      OFF_PWR:     return 16'h7FF0;
      default:     return 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/cmx_access.sv
module cmx_access #(
  parameter int ADDR_W      = 10,
  parameter int SPACE_BYTES = 256,
  localparam int NREG       = SPACE_BYTES / 2,
  localparam int IDX_W      = $clog2(NREG)
) (
  input  logic              valid,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              word_rd,
  output logic              word_wr,
  output logic              any_rd,
  output logic [IDX_W-1:0]  idx
);
  import cmx_pkg::*;
  logic in_space;
  assign in_space = (addr < ADDR_W'(SPACE_BYTES));
  assign idx      = addr[IDX_W:1];
  assign any_rd   = valid && !write;
  assign word_rd  = any_rd && (size == SZ_WORD) && in_space;
  assign word_wr  = valid && write && (size == SZ_WORD) && in_space;
endmodule

// File: rtl/cmx_write_policy.sv
module cmx_write_policy (
  input  logic        wr,
  input  logic [7:0]  off,
  input  logic [15:0] wdata,
  input  logic [15:0] cur,
  input  logic [15:0] ext_cur,
  output logic        store_en,
  output logic [15:0] store_val,
  output logic        soft_rst,
  output logic        force_av,
  output logic        force_mic
);
  import cmx_pkg::*;
  logic gate_ok;

  always_comb begin
    case (off)
      OFF_DAC, OFF_ADC: gate_ok = ext_cur[EXT_VAR_AUDIO];
      OFF_MIC:          gate_ok = ext_cur[EXT_VAR_MIC];
      OFF_RESET:        gate_ok = 1'b0;
      default:          gate_ok = !cmx_frozen(off);
    endcase
  end

  assign soft_rst  = wr && (off == OFF_RESET);
  assign store_en  = wr && gate_ok;
  assign store_val = (off == OFF_PWR)
                     ? ((wdata & cmx_keep_mask(off)) | (cur & 16'h000F))
                     : (wdata & cmx_keep_mask(off));
  assign force_av  = wr && (off == OFF_EXTCTL) && !wdata[EXT_VAR_AUDIO];
  assign force_mic = wr && (off == OFF_EXTCTL) && !wdata[EXT_VAR_MIC];
endmodule

// File: rtl/cmx_fields.sv
module cmx_fields (
  input  logic [15:0] master_q,
  input  logic [15:0] pcm_q,
  input  logic [15:0] gain_q,
  input  logic [15:0] sel_q,
  output logic        master_mute,
  output logic [5:0]  master_att_l,
  output logic [5:0]  master_att_r,
  output logic        pcm_mute,
  output logic [4:0]  pcm_att_l,
  output logic [4:0]  pcm_att_r,
  output logic        rec_mute,
  output logic [3:0]  rec_gain_l,
  output logic [3:0]  rec_gain_r,
  output logic [2:0]  rec_src_l,
  output logic [2:0]  rec_src_r
);
  assign master_mute  = master_q[15];
  assign master_att_l = master_q[13:8];
  assign master_att_r = master_q[5:0];
  assign pcm_mute     = pcm_q[15];
  assign pcm_att_l    = pcm_q[12:8];
  assign pcm_att_r    = pcm_q[4:0];
  assign rec_mute     = gain_q[15];
  assign rec_gain_l   = gain_q[11:8];
  assign rec_gain_r   = gain_q[3:0];
  assign rec_src_l    = sel_q[10:8];
  assign rec_src_r    = sel_q[2:0];
endmodule

// File: rtl/cmx_top.sv
module cmx_top #(
  parameter int ADDR_W      = 10,
  parameter int SPACE_BYTES = 256,
  localparam int NREG       = SPACE_BYTES / 2,
  localparam int IDX_W      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [15:0]       acc_wdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              master_mute,
  output logic [5:0]        master_att_l,
  output logic [5:0]        master_att_r,
  output logic              pcm_mute,
  output logic [4:0]        pcm_att_l,
  output logic [4:0]        pcm_att_r,
  output logic              rec_mute,
  output logic [3:0]        rec_gain_l,
  output logic [3:0]        rec_gain_r,
  output logic [2:0]        rec_src_l,
  output logic [2:0]        rec_src_r,
  output logic [15:0]       rate_dac,
  output logic [15:0]       rate_adc,
  output logic [15:0]       rate_mic
);
  import cmx_pkg::*;

  logic [15:0]      regs [NREG];
  logic             word_rd, word_wr, any_rd;
  logic [IDX_W-1:0] idx;
  logic [7:0]       off;
  logic             store_en, soft_rst_ev, force_av, force_mic;
  logic [15:0]      store_val;

  assign off = 8'({idx, 1'b0});

  cmx_access #(.ADDR_W(ADDR_W), .SPACE_BYTES(SPACE_BYTES)) u_access (
    .valid(acc_valid), .write(acc_write), .size(acc_size), .addr(acc_addr),
    .word_rd(word_rd), .word_wr(word_wr), .any_rd(any_rd), .idx(idx)
  );

  cmx_write_policy u_policy (
    .wr(word_wr), .off(off), .wdata(acc_wdata), .cur(regs[idx]),
    .ext_cur(regs[OFF_EXTCTL[7:1]]),
    .store_en(store_en), .store_val(store_val), .soft_rst(soft_rst_ev),
    .force_av(force_av), .force_mic(force_mic)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst_ev) begin
      for (int i = 0; i < NREG; i++) regs[i] <= cmx_default(8'(2 * i));
    end else begin
      if (store_en) regs[idx] <= store_val;
      if (force_av) begin
        regs[OFF_DAC[7:1]] <= RATE_48K;
        regs[OFF_ADC[7:1]] <= RATE_48K;
      end
      if (force_mic) regs[OFF_MIC[7:1]] <= RATE_48K;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= any_rd;
      rd_data  <= word_rd ? regs[idx] : 16'hFFFF;
    end
  end

  cmx_fields u_fields (
    .master_q(regs[OFF_MASTER[7:1]]), .pcm_q(regs[OFF_PCM[7:1]]),
    .gain_q(regs[OFF_RECGAIN[7:1]]), .sel_q(regs[OFF_RECSEL[7:1]]),
    .master_mute(master_mute), .master_att_l(master_att_l),
    .master_att_r(master_att_r), .pcm_mute(pcm_mute),
    .pcm_att_l(pcm_att_l), .pcm_att_r(pcm_att_r), .rec_mute(rec_mute),
    .rec_gain_l(rec_gain_l), .rec_gain_r(rec_gain_r),
    .rec_src_l(rec_src_l), .rec_src_r(rec_src_r)
  );

  assign rate_dac = regs[OFF_DAC[7:1]];
  assign rate_adc = regs[OFF_ADC[7:1]];
  assign rate_mic = regs[OFF_MIC[7:1]];

  logic vra_q;
  assign vra_q = regs[OFF_EXTCTL[7:1]][EXT_VAR_AUDIO];

  // R1: rejected sizes read as all ones
  a_r1_nonword_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size != SZ_WORD) |=> (rd_data == 16'hFFFF));
  // R2: master volume never holds bits outside its mask
  a_r2_master_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[OFF_MASTER[7:1]] & ~16'hBF3F) == 16'h0);
  // R3: power-down status nibble is sticky
  a_r3_pwr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    regs[OFF_PWR[7:1]][3:0] == 4'hF);
  // R4: identity value stays put
  a_r4_vendor_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    regs[OFF_VID1[7:1]] == 16'h8384);
  // R5: DAC rate frozen while variable-rate audio is off
  a_r5_dac_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!vra_q && !soft_rst_ev) |=> $stable(rate_dac));
  // R8: soft reset restores master volume default
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_ev |=> (master_mute && master_att_l == 6'd0 && rate_mic == RATE_48K));
  // R11: read valid follows a read strobe
  a_r11_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);
endmodule

// File: tb/cmx_top_tb.sv
`timescale 1ns/1ps
module cmx_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_size = 2'd1;
  logic [9:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        master_mute, pcm_mute, rec_mute;
  logic [5:0]  master_att_l, master_att_r;
  logic [4:0]  pcm_att_l, pcm_att_r;
  logic [3:0]  rec_gain_l, rec_gain_r;
  logic [2:0]  rec_src_l, rec_src_r;
  logic [15:0] rate_dac, rate_adc, rate_mic;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cmx_top u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .master_mute(master_mute), .master_att_l(master_att_l),
    .master_att_r(master_att_r), .pcm_mute(pcm_mute), .pcm_att_l(pcm_att_l),
    .pcm_att_r(pcm_att_r), .rec_mute(rec_mute), .rec_gain_l(rec_gain_l),
    .rec_gain_r(rec_gain_r), .rec_src_l(rec_src_l), .rec_src_r(rec_src_r),
    .rate_dac(rate_dac), .rate_adc(rate_adc), .rate_mic(rate_mic)
  );

  // {size, write addr, wdata, read addr, expected, requirement}
  localparam int NV = 24;
  localparam logic [61:0] VEC [NV] = '{
    {2'd1, 10'h002, 16'hFFFF, 10'h002, 16'hBF3F, 8'd2},   // R2 master
    {2'd1, 10'h018, 16'hFFFF, 10'h018, 16'h9F1F, 8'd2},   // R2 pcm
    {2'd1, 10'h01C, 16'hFFFF, 10'h01C, 16'h8F0F, 8'd2},   // R2 gain
    {2'd1, 10'h01A, 16'hFFFF, 10'h01A, 16'h0707, 8'd2},   // R2 select
    {2'd1, 10'h026, 16'hFFFF, 10'h026, 16'h7FFF, 8'd3},   // R3
    {2'd1, 10'h026, 16'h0000, 10'h026, 16'h000F, 8'd3},   // R3
    {2'd1, 10'h07C, 16'h1234, 10'h07C, 16'h8384, 8'd4},   // R4
    {2'd1, 10'h07E, 16'h1234, 10'h07E, 16'h7600, 8'd4},   // R4
    {2'd1, 10'h028, 16'h1234, 10'h028, 16'h0809, 8'd4},   // R4
    {2'd1, 10'h004, 16'hFFFF, 10'h004, 16'h0000, 8'd7},   // R7
    {2'd1, 10'h022, 16'hABCD, 10'h022, 16'h0000, 8'd7},   // R7
    {2'd1, 10'h040, 16'hBEEF, 10'h040, 16'hBEEF, 8'd7},   // R7
    {2'd1, 10'h02E, 16'h1111, 10'h02E, 16'h1111, 8'd7},   // R7
    {2'd0, 10'h040, 16'h0000, 10'h040, 16'hBEEF, 8'd1},   // R1 byte
    {2'd2, 10'h040, 16'h0000, 10'h040, 16'hBEEF, 8'd1},   // R1 dword
    {2'd1, 10'h140, 16'h0000, 10'h040, 16'hBEEF, 8'd1},   // R1 range
    {2'd1, 10'h02C, 16'hAC44, 10'h02C, 16'hAC44, 8'd5},   // R5
    {2'd1, 10'h02A, 16'h0008, 10'h02C, 16'hBB80, 8'd6},   // R6
    {2'd1, 10'h032, 16'h5622, 10'h032, 16'hBB80, 8'd5},   // R5
    {2'd1, 10'h034, 16'h1F40, 10'h034, 16'h1F40, 8'd5},   // R5
    {2'd1, 10'h02A, 16'h0000, 10'h034, 16'hBB80, 8'd6},   // R6
    {2'd1, 10'h034, 16'h1F40, 10'h034, 16'hBB80, 8'd5},   // R5
    {2'd1, 10'h02A, 16'h0001, 10'h02A, 16'h0001, 8'd6},   // R6
    {2'd1, 10'h02C, 16'h3E80, 10'h02C, 16'h3E80, 8'd5}    // R5
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = sz; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [9:0] a, output logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_size = sz; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    checks++;
    if (rd_valid !== 1'b1) begin
      errors++;
      $display("FAIL R11: actual rd_valid %0b expected 1", rd_valid);
    end
    d = rd_data;
  endtask

  initial begin
    #(8ns * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 and R11 reset state
    check("R11", 16'(rd_valid), 16'h0);
    check("R9", rate_dac, 16'hBB80);
    check("R9", rate_adc, 16'hBB80);
    check("R9", rate_mic, 16'hBB80);
    rd(2'd1, 10'h026, v); check("R9", v, 16'h000F);
    rd(2'd1, 10'h018, v); check("R9", v, 16'h8808);
    rd(2'd1, 10'h02A, v); check("R9", v, 16'h0009);
    rd(2'd1, 10'h030, v); check("R9", v, 16'hBB80);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][61:60], VEC[i][59:50], VEC[i][49:34]);
      rd(2'd1, VEC[i][33:24], v);
      check($sformatf("R%0d row %0d", VEC[i][7:0], i), v, VEC[i][23:8]);
    end
    check("R10", rate_dac, 16'h3E80);

    // R10 decoded fields
    wr(2'd1, 10'h002, 16'h0A05);
    @(negedge clk);
    check("R10", {15'h0, master_mute}, 16'h0);
    check("R10", {10'h0, master_att_l}, 16'h000A);
    check("R10", {10'h0, master_att_r}, 16'h0005);
    wr(2'd1, 10'h018, 16'h8813);
    check("R10", {11'h0, pcm_att_l, pcm_mute}, {11'h0, 5'h08, 1'b1});
    check("R10", {11'h0, pcm_att_r}, 16'h0013);
    wr(2'd1, 10'h01A, 16'h0503);
    check("R10", {10'h0, rec_src_l, rec_src_r}, {10'h0, 3'd5, 3'd3});
    wr(2'd1, 10'h01C, 16'h0C03);
    check("R10", {7'h0, rec_mute, rec_gain_l, rec_gain_r}, {7'h0, 1'b0, 4'hC, 4'h3});

    // R1 rejected reads
    rd(2'd0, 10'h002, v); check("R1", v, 16'hFFFF);
    rd(2'd2, 10'h002, v); check("R1", v, 16'hFFFF);
    rd(2'd1, 10'h100, v); check("R1", v, 16'hFFFF);

    // R8 soft reset
    wr(2'd1, 10'h000, 16'h1234);
    check("R8", rate_dac, 16'hBB80);
    rd(2'd1, 10'h040, v); check("R8", v, 16'h0000);
    rd(2'd1, 10'h002, v); check("R8", v, 16'h8000);
    rd(2'd1, 10'h01C, v); check("R8", v, 16'h8808);
    rd(2'd1, 10'h02A, v); check("R8", v, 16'h0009);
    rd(2'd1, 10'h02E, v); check("R8", v, 16'hBB80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule